// File: doc/BRIEF.md
# Handshaked Command Packet Transmitter

This block sends short host command packets to a keyboard and system controller over a UART with modem flow-control lines. A host loads a payload of one to `MAX_LEN` bytes and pulses `start`. The sequencer then raises RTS and waits for the far end to answer with CTS. Next it hands the payload bytes, followed by a computed check byte, to a UART transmitter one at a time. Before each byte, and again after it, the sequencer waits until the transmitter reports that both its holding register and its shift register are empty. After the last byte drains, it holds RTS for a fixed guard time and then releases it.

The UART serializer is not part of this block. It is seen only through a single "fully empty" status input and a one-cycle write strobe with a data byte. A request that arrives while a transfer is in progress is refused with a reject pulse, so the host can retry later. If CTS never answers, a timeout ends the attempt and releases RTS. While RTS is up, the interrupt for incoming receive data is held back. Typical payloads are a display contrast command (0x83, 0x43, level) and a backlight command (0x85, 0x41, 0x02, level, 0x02).

Top module: `cmd_packet_tx`

## Requirements
- R1: After reset, `rts`, `busy`, `tx_wr`, `done`, `rejected`, `timeout_err` and `rx_irq` are all low.
- R2: A `start` in the idle state with `len` from 1 to MAX_LEN raises `rts` and `busy` on the next cycle. No byte is written while `cts` is low.
- R3: A `start` while `busy` is high, or with `len` equal to 0 or above MAX_LEN, gives a one-cycle `rejected` pulse. The transfer in progress is not disturbed.
- R4: An accepted transfer writes exactly `len`+1 bytes. Each write is a single-cycle `tx_wr` pulse. The bytes go out as payload byte 0 (bits 7:0 of `payload`), then byte 1 (bits 15:8), and so on, with the check byte last.
- R5: `tx_wr` is only issued in a cycle that follows a cycle in which `tx_empty` was high. After each write, the sequencer waits for `tx_empty` to return high before it moves on. The transmitter must drop `tx_empty` on the clock edge that takes the write.
- R6: The check byte is the XOR of all payload bytes. If bit 7 of that XOR is 1, the result is further XORed with 0xC0.
- R7: `rts` falls exactly GUARD_CYC+1 cycles after the edge at which `tx_empty` first returns high after the check byte, where GUARD_CYC = CLK_HZ/1e6 × GUARD_US. `done` pulses for one cycle as `rts` falls.
- R8: If `cts` stays low, `rts` is held for exactly CTS_WAIT_CYC cycles. It then falls together with a one-cycle `timeout_err` pulse, and no byte is written.
- R9: `rx_irq` follows `rx_avail` one cycle later, but is forced low whenever `rts` is high or a transfer is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send the loaded payload |
| len | input | $clog2(MAX_LEN+1) | Payload length in bytes |
| payload | input | MAX_LEN*8 | Payload, byte i at bits 8i+7:8i |
| cts | input | 1 | Clear-to-send from far end |
| tx_empty | input | 1 | Transmitter holding and shift registers both empty |
| rx_avail | input | 1 | Receive data available request |
| rts | output | 1 | Request-to-send |
| tx_wr | output | 1 | One-cycle write strobe to the transmitter |
| tx_data | output | 8 | Byte to be written |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed pulse |
| rejected | output | 1 | Request refused pulse |
| timeout_err | output | 1 | CTS wait expired pulse |
| rx_irq | output | 1 | Gated receive interrupt |

## Verification
The bench builds the block with MAX_LEN=5, CLK_HZ=2 MHz, GUARD_US=1500 (a 3000-cycle guard) and CTS_WAIT_CYC=40. With these values, every payload length from 1 to the maximum can be swept with several byte patterns and transmitter drain delays, including patterns that set and clear bit 7 of the XOR. The guard and timeout windows are short enough to be measured cycle-exactly. The two display commands fit inside the maximum length, and the reject, timeout and interrupt hold-off cases fall between transfers.

// File: rtl/cmdtx_pkg.sv
package cmdtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTS,
    ST_PRE,
    ST_SETTLE,
    ST_DRAIN,
    ST_GUARD
  } cmdtx_state_t;
endpackage

// File: rtl/cmdtx_timer.sv
module cmdtx_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load)
      count <= value;
    else if (tick && count != '0)
      count <= count - 1'b1;
  end

  assign expired = (count == '0);
endmodule

// File: rtl/cmdtx_fold.sv
module cmdtx_fold (
  input  logic [7:0] acc,
  output logic [7:0] chk
);
  always_comb begin
    chk = acc;
    if (acc[7])
      chk = acc ^ 8'hC0;
  end
endmodule

// File: rtl/cmd_packet_tx.sv
module cmd_packet_tx #(
  parameter int MAX_LEN      = 8,
  parameter int CLK_HZ       = 100_000_000,
  parameter int GUARD_US     = 1500,
  parameter int CTS_WAIT_CYC = 100_000,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LW-1:0]      len,
  input  logic [MAX_LEN*8-1:0] payload,
  input  logic               cts,
  input  logic               tx_empty,
  input  logic               rx_avail,
  output logic               rts,
  output logic               tx_wr,
  output logic [7:0]         tx_data,
  output logic               busy,
  output logic               done,
  output logic               rejected,
  output logic               timeout_err,
  output logic               rx_irq
);
  import cmdtx_pkg::*;

  localparam int GUARD_CYC = (CLK_HZ / 1_000_000) * GUARD_US;
  localparam int MAXC      = (GUARD_CYC > CTS_WAIT_CYC) ? GUARD_CYC : CTS_WAIT_CYC;
  localparam int TW        = $clog2(MAXC + 1);
  localparam int DEPTH     = 1 << LW;

  cmdtx_state_t state;
  logic [7:0]    pl_q [DEPTH];
  logic [LW-1:0] len_q;
  logic [LW-1:0] idx;
  logic [7:0]    acc;
  logic [7:0]    chk;

  logic          len_ok;
  logic          accept;
  logic          last_byte;
  logic          tmr_load;
  logic [TW-1:0] tmr_value;
  logic          tmr_tick;
  logic          tmr_expired;

  assign len_ok    = (len != '0) && (len <= LW'(MAX_LEN));
  assign accept    = (state == ST_IDLE) && start && len_ok;
  assign last_byte = (idx == len_q);

  always_comb begin
    tmr_load  = 1'b0;
    tmr_value = TW'(CTS_WAIT_CYC - 1);
    if (accept) begin
      tmr_load = 1'b1;
    end else if (state == ST_DRAIN && tx_empty && last_byte) begin
      tmr_load  = 1'b1;
      tmr_value = TW'(GUARD_CYC - 1);
    end
  end

  assign tmr_tick = (state == ST_CTS) || (state == ST_GUARD);

  cmdtx_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .value   (tmr_value),
    .tick    (tmr_tick),
    .expired (tmr_expired)
  );

  cmdtx_fold u_fold (
    .acc (acc),
    .chk (chk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      len_q       <= '0;
      idx         <= '0;
      acc         <= '0;
      rts         <= 1'b0;
      busy        <= 1'b0;
      tx_wr       <= 1'b0;
      tx_data     <= '0;
      done        <= 1'b0;
      rejected    <= 1'b0;
      timeout_err <= 1'b0;
      rx_irq      <= 1'b0;
      for (int i = 0; i < DEPTH; i++) pl_q[i] <= '0;
    end else begin
      tx_wr       <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      rejected    <= start && !accept;
      rx_irq      <= rx_avail && !rts && !start;

      case (state)
        ST_IDLE: begin
          if (accept) begin
            for (int i = 0; i < DEPTH; i++)
              pl_q[i] <= (i < MAX_LEN) ? payload[(i % MAX_LEN)*8 +: 8] : 8'h00;
            len_q <= len;
            idx   <= '0;
            acc   <= '0;
            rts   <= 1'b1;
            busy  <= 1'b1;
            state <= ST_CTS;
          end
        end
        ST_CTS: begin
          if (cts) begin
            state <= ST_PRE;
          end else if (tmr_expired) begin
            rts         <= 1'b0;
            busy        <= 1'b0;
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_PRE: begin
          if (tx_empty) begin
            tx_wr <= 1'b1;
            if (last_byte) begin
              tx_data <= chk;
            end else begin
              tx_data <= pl_q[idx];
              acc     <= acc ^ pl_q[idx];
            end
            state <= ST_SETTLE;
          end
        end
        ST_SETTLE: state <= ST_DRAIN;
        ST_DRAIN: begin
          if (tx_empty) begin
            if (last_byte) begin
              state <= ST_GUARD;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_PRE;
            end
          end
        end
        ST_GUARD: begin
          if (tmr_expired) begin
            rts   <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_packet_tx_chk.sv
module cmd_packet_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic tx_empty,
  input logic rts,
  input logic tx_wr,
  input logic done,
  input logic rejected,
  input logic timeout_err,
  input logic rx_irq
);
  // R2
  wr_needs_rts_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr |-> rts);

  // R4
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_wr);

  // R5
  wr_after_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_wr) |-> $past(tx_empty));

  // R3
  reject_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rejected) |-> $past(start));

  // R7
  done_drops_rts_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!rts && $past(rts)));

  // R8
  timeout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!rts && !tx_wr));

  // R9
  irq_held_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> !rts);
endmodule

bind cmd_packet_tx cmd_packet_tx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .tx_empty    (tx_empty),
  .rts         (rts),
  .tx_wr       (tx_wr),
  .done        (done),
  .rejected    (rejected),
  .timeout_err (timeout_err),
  .rx_irq      (rx_irq)
);

// File: tb/cmd_packet_tx_test.sv
module cmd_packet_tx_test;
  localparam int MAX_LEN = 5;
  localparam int CLK_HZ  = 2_000_000;
  localparam int GUARD_US = 1500;
  localparam int CTSW    = 40;
  localparam int GUARD   = (CLK_HZ / 1_000_000) * GUARD_US;
  localparam int LW      = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LW-1:0] len = '0;
  logic [MAX_LEN*8-1:0] payload = '0;
  logic cts = 1'b0;
  logic tx_empty;
  logic rx_avail = 1'b0;
  logic rts, tx_wr, busy, done, rejected, timeout_err, rx_irq;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cmd_packet_tx #(.MAX_LEN(MAX_LEN), .CLK_HZ(CLK_HZ), .GUARD_US(GUARD_US),
                  .CTS_WAIT_CYC(CTSW)) uut (
    .clk(clk), .rst(rst), .start(start), .len(len), .payload(payload),
    .cts(cts), .tx_empty(tx_empty), .rx_avail(rx_avail), .rts(rts),
    .tx_wr(tx_wr), .tx_data(tx_data), .busy(busy), .done(done),
    .rejected(rejected), .timeout_err(timeout_err), .rx_irq(rx_irq));

  // transmitter and far-end models
  logic [7:0] cap [0:15];
  int ncap = 0;
  int drain_dly = 3;
  int dcnt = 0;
  int wr_while_busy = 0;
  int wr_no_cts = 0;
  logic cts_en = 1'b1;
  int cts_dly = 4;
  int ccnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      tx_empty <= 1'b1;
    end else if (tx_wr) begin
      if (ncap < 16) cap[ncap] <= tx_data;
      ncap <= ncap + 1;
      if (!tx_empty) wr_while_busy <= wr_while_busy + 1;
      if (!cts) wr_no_cts <= wr_no_cts + 1;
      tx_empty <= 1'b0;
      dcnt <= drain_dly;
    end else if (!tx_empty) begin
      if (dcnt == 0) tx_empty <= 1'b1;
      else dcnt <= dcnt - 1;
    end
  end

  always @(posedge clk) begin
    if (rst || !rts || !cts_en) begin
      cts <= 1'b0; ccnt <= 0;
    end else if (ccnt >= cts_dly) cts <= 1'b1;
    else ccnt <= ccnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fold(input logic [7:0] b [0:7], input int n);
    logic [7:0] x = 8'h00;
    for (int i = 0; i < n; i++) x ^= b[i];
    if (x[7]) x ^= 8'hC0;
    return x;
  endfunction

  task automatic send(input logic [7:0] b [0:7], input int n, input int dly,
                      input bit poke_reject);
    int cyc = 0;
    int gcnt = 0;
    int irq_bad = 0;
    bit rej_seen = 0;
    logic [7:0] ck;
    drain_dly = dly;
    ncap = 0;
    @(negedge clk);
    len = LW'(n);
    for (int i = 0; i < MAX_LEN; i++) payload[8*i +: 8] = (i < n) ? b[i] : 8'h00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(rts && busy, "R2 rts/busy after start", {rts, busy}, 3);
    forever begin
      @(negedge clk);
      cyc++;
      if (poke_reject && cyc == 6) begin
        start = 1'b1; len = 1; payload = '1;
      end
      if (poke_reject && cyc == 7) begin
        start = 1'b0;
        rej_seen = rejected;
      end
      if (rts && rx_irq) irq_bad++;
      if (ncap == n + 1 && tx_empty && rts) gcnt++;
      if (done || cyc > 20000) break;
    end
    check(done && !rts, "R7 done with rts low", {done, rts}, 2);
    if (poke_reject) check(rej_seen, "R3 reject while busy", rej_seen, 1);
    check(ncap == n + 1, "R4 byte count", ncap, n + 1);
    for (int i = 0; i < n; i++)
      check(cap[i] == b[i], "R4 payload order", cap[i], b[i]);
    ck = fold(b, n);
    check(cap[n] == ck, "R6 check byte", cap[n], ck);
    check(gcnt == GUARD + 1, "R7 guard length", gcnt, GUARD + 1);
    check(wr_while_busy == 0, "R5 write into non-empty transmitter", wr_while_busy, 0);
    check(wr_no_cts == 0, "R2 write before cts", wr_no_cts, 0);
    check(irq_bad == 0, "R9 irq during rts", irq_bad, 0);
  endtask

  initial begin : watchdog
    repeat (190_000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b [0:7];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!rts && !busy && !tx_wr && !done && !rejected && !timeout_err && !rx_irq,
          "R1 reset state", {rts, busy, tx_wr, done, rejected, timeout_err, rx_irq}, 0);

    rx_avail = 1'b1;
    // R3 zero length refused
    len = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(rejected && !rts, "R3 zero length", {rejected, rts}, 2);
    @(negedge clk);
    check(!rejected, "R3 reject is one pulse", rejected, 0);

    // R9 idle irq passes through
    check(rx_irq, "R9 irq idle", rx_irq, 1);

    // sweep lengths and byte patterns
    for (int n = 1; n <= MAX_LEN; n++) begin
      for (int p = 0; p < 3; p++) begin
        for (int i = 0; i < 8; i++) b[i] = 8'((n * 37 + i * 91 + p * 113) & 255);
        cts_dly = p * 3;
        send(b, n, p + 1, (n == 3 && p == 1));
      end
    end

    // display contrast and backlight commands
    b[0] = 8'h83; b[1] = 8'h43; b[2] = 8'h2A;
    send(b, 3, 2, 1'b0);
    b[0] = 8'h85; b[1] = 8'h41; b[2] = 8'h02; b[3] = 8'hF0; b[4] = 8'h02;
    send(b, 5, 1, 1'b0);

    // R9 irq returns after transfer
    repeat (2) @(negedge clk);
    check(rx_irq, "R9 irq after rts drop", rx_irq, 1);

    // R8 cts never answers
    cts_en = 1'b0;
    ncap = 0;
    begin
      int hi = 0;
      bit err = 0;
      @(negedge clk);
      len = 2; payload = 40'h11; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < CTSW + 10; c++) begin
        if (rts) hi++;
        if (timeout_err) begin err = 1; break; end
        @(negedge clk);
      end
      check(err && !rts, "R8 timeout pulse with rts low", {err, rts}, 2);
      check(hi == CTSW, "R8 cts wait length", hi, CTSW);
      check(ncap == 0, "R8 no bytes written", ncap, 0);
      @(negedge clk);
      check(!timeout_err && !busy, "R8 pulse ends idle", {timeout_err, busy}, 0);
    end
    cts_en = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule